// File: doc/BRIEF.md
# Paged DMA Address Generator

This block produces the physical bus address for a single DMA channel. A 16-bit current-address counter gives the low part of the address. Two 8-bit page registers give the high part: a page register and, above it, a high-page register. The channel can move bytes or 16-bit words. On a word channel the counter holds a word address. It is shifted up by one bit, and the lowest page bit is dropped, so each page selects a 128K window instead of a 64K one.

Software programs the channel through separate write strobes that share one data bus: mode, address, count, page and high page. Each accepted transfer strobe advances the counter by one unit and lowers the remaining count. On the transfer that exhausts the count, the block gives a one-cycle terminal-count pulse. After that pulse the channel either stops or, in auto-initialise mode, reloads its programmed start values.

Writing the high page, which is the last step of setup, turns on extended mode. In extended mode a counter overflow carries into the page fields. Writing the page register turns extended mode off again, and the address then wraps inside its window.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After a synchronous reset, every output is zero: the address, count, terminal count, active flag and extended flag.
- R2: For a byte channel (mode bit 1 clear), the address is {high page, page, counter} with the counter in bits [15:0].
- R3: For a word channel (mode bit 1 set), the address is {high page, page[7:1], counter, 1'b0}. Page bit 0 has no effect on the address.
- R4: Each accepted transfer adds one to the counter. When extended mode is off, the counter wraps from 0xFFFF to 0x0000 and both page registers stay unchanged.
- R5: A high-page write sets the extended flag. A page write clears it, unless a high-page write happens in the same cycle.
- R6: In extended mode, a counter wrap adds one to {high page, page} on a byte channel, or to {high page, page[7:1]} on a word channel, where page bit 0 is kept.
- R7: A count write loads the value N and makes the channel active. Each accepted transfer decrements the count. Terminal count pulses for one cycle on transfer N+1, the one made while the count is 0x0000, so 0xFFFF gives 65536 transfers.
- R8: Without auto-initialise (mode bit 0 clear), the channel goes inactive after terminal count and its count reads 0xFFFF. Later transfer strobes change neither the address nor the count.
- R9: With auto-initialise set, terminal count reloads the counter, count, page and high page from their last written values, and the channel stays active. The reload takes priority over a page carry in the same cycle.
- R10: A transfer strobe in a cycle with any register write is ignored.
- R11: An address write sets both the current counter and the start value used by the auto-initialise reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode_i | input | 1 | Mode write strobe: data bit 0 is auto-initialise, bit 1 is word channel |
| wr_addr_i | input | 1 | Address counter write strobe |
| wr_count_i | input | 1 | Count write strobe (transfers minus one); arms the channel |
| wr_page_i | input | 1 | Page write strobe; clears extended mode |
| wr_hpage_i | input | 1 | High-page write strobe; sets extended mode |
| wr_data_i | input | 16 | Write data shared by all strobes (pages use the low 8 bits) |
| xfer_i | input | 1 | Transfer strobe, one per moved unit |
| phys_addr_o | output | 32 | Composed physical address |
| tc_o | output | 1 | Terminal-count pulse |
| active_o | output | 1 | Channel accepts transfers |
| ext_mode_o | output | 1 | Extended (carry-into-page) mode flag |
| count_o | output | 16 | Current remaining count minus one |

## Verification
On every cycle, the assertions check four things. The counter steps by exactly one per accepted transfer. The pages hold still while extended mode is off. A high-page write leaves the extended flag set. The count is frozen while the channel is idle, and after each terminal count it sits at either the reload value or 0xFFFF. The remaining behaviours can only be shown by the bench's scenarios against its reference model:

- the exact address layout for byte and word channels;
- carries crossing the full page field;
- the auto-initialise reload winning over a simultaneous carry;
- a write blocking a transfer;
- the 65536-transfer count boundary.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int MODE_W        = 2;
  localparam int MODE_AUTO_BIT = 0;
  localparam int MODE_WORD_BIT = 1;

  typedef enum logic {
    CH_BYTE = 1'b0,
    CH_WORD = 1'b1
  } chan_kind_e;
endpackage

// File: rtl/dma_addr_counter.sv
module dma_addr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             xfer_ok_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      base_q <= '0;
    end else if (wr_addr_i) begin
      cur_q  <= wr_data_i;
      base_q <= wr_data_i;
    end else if (reload_i) begin
      cur_q  <= base_q;
    end else if (xfer_ok_i) begin
      cur_q  <= cur_q + 1'b1;
    end
  end

  assign cur_o   = cur_q;
  assign carry_o = xfer_ok_i & (&cur_q);

  // R4: one unit per accepted transfer, wrapping at the counter width
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok_i && !reload_i && !wr_addr_i) |=> (cur_q == CNT_W'($past(cur_q) + 1'b1)));
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
  import dma_pg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mode_i,
  input  logic             wr_count_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             xfer_ok_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             tc_o,
  output logic             reload_o,
  output chan_kind_e       kind_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  base_q;
  logic              active_q;
  logic              tc_q;
  logic [MODE_W-1:0] mode_q;
  logic              last_xfer;
  logic              auto_en;

  assign auto_en   = mode_q[MODE_AUTO_BIT];
  assign last_xfer = xfer_ok_i & (cnt_q == '0);
  assign reload_o  = last_xfer & auto_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      base_q   <= '0;
      active_q <= 1'b0;
      tc_q     <= 1'b0;
      mode_q   <= '0;
    end else begin
      tc_q <= 1'b0;
      if (wr_mode_i) mode_q <= wr_data_i[MODE_W-1:0];
      if (wr_count_i) begin
        cnt_q    <= wr_data_i;
        base_q   <= wr_data_i;
        active_q <= 1'b1;
      end else if (last_xfer) begin
        tc_q <= 1'b1;
        if (auto_en) begin
          cnt_q <= base_q;
        end else begin
          cnt_q    <= '1;
          active_q <= 1'b0;
        end
      end else if (xfer_ok_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count_o  = cnt_q;
  assign active_o = active_q;
  assign tc_o     = tc_q;
  assign kind_o   = chan_kind_e'(mode_q[MODE_WORD_BIT]);

  // R7/R8/R9: state left behind by a terminal count
  p_tc_after_r7: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (auto_en ? (cnt_q == base_q && active_q) : (cnt_q == '1 && !active_q)));
  // R8: an idle channel never moves its count
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !wr_count_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_page_unit.sv
module dma_page_unit
  import dma_pg_pkg::*;
#(
  parameter int PG_W = 8,
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_page_i,
  input  logic            wr_hpage_i,
  input  logic [PG_W-1:0] page_data_i,
  input  logic [HP_W-1:0] hpage_data_i,
  input  logic            carry_i,
  input  logic            reload_i,
  input  chan_kind_e      kind_i,
  output logic [PG_W-1:0] page_o,
  output logic [HP_W-1:0] hpage_o,
  output logic            ext_o
);
  localparam int FULL_W = HP_W + PG_W;
  localparam int WIDE_W = HP_W + PG_W - 1;

  logic [PG_W-1:0]   page_q, page_base_q;
  logic [HP_W-1:0]   hpage_q, hpage_base_q;
  logic              ext_q;
  logic [FULL_W-1:0] byte_sum;
  logic [WIDE_W-1:0] word_sum;

  assign byte_sum = {hpage_q, page_q} + 1'b1;
  assign word_sum = {hpage_q, page_q[PG_W-1:1]} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q       <= '0;
      page_base_q  <= '0;
      hpage_q      <= '0;
      hpage_base_q <= '0;
      ext_q        <= 1'b0;
    end else if (wr_page_i || wr_hpage_i) begin
      if (wr_page_i) begin
        page_q      <= page_data_i;
        page_base_q <= page_data_i;
      end
      if (wr_hpage_i) begin
        hpage_q      <= hpage_data_i;
        hpage_base_q <= hpage_data_i;
      end
      ext_q <= wr_hpage_i;
    end else if (reload_i) begin
      page_q  <= page_base_q;
      hpage_q <= hpage_base_q;
    end else if (carry_i && ext_q) begin
      if (kind_i == CH_WORD) begin
        {hpage_q, page_q[PG_W-1:1]} <= word_sum;
      end else begin
        {hpage_q, page_q} <= byte_sum;
      end
    end
  end

  assign page_o  = page_q;
  assign hpage_o = hpage_q;
  assign ext_o   = ext_q;

  // R4: pages are frozen while carries are not enabled
  p_window_r4: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && !wr_page_i && !wr_hpage_i && !reload_i) |=> ($stable(page_q) && $stable(hpage_q)));
  // R5: high-page write leaves the extended flag set
  p_ext_set_r5: assert property (@(posedge clk) disable iff (rst)
    wr_hpage_i |=> ext_q);
endmodule

// File: rtl/dma_addr_compose.sv
module dma_addr_compose
  import dma_pg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PG_W  = 8,
  parameter int HP_W  = 8,
  localparam int ADDR_W = HP_W + PG_W + CNT_W
) (
  input  logic [CNT_W-1:0]  cur_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [HP_W-1:0]   hpage_i,
  input  chan_kind_e        kind_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] byte_addr;
  logic [ADDR_W-1:0] word_addr;

  assign byte_addr = {hpage_i, page_i, cur_i};
  assign word_addr = {hpage_i, page_i[PG_W-1:1], cur_i, 1'b0};
  assign addr_o    = (kind_i == CH_WORD) ? word_addr : byte_addr;
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_pg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PG_W  = 8,
  parameter int HP_W  = 8,
  localparam int ADDR_W = HP_W + PG_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode_i,
  input  logic              wr_addr_i,
  input  logic              wr_count_i,
  input  logic              wr_page_i,
  input  logic              wr_hpage_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              tc_o,
  output logic              active_o,
  output logic              ext_mode_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             any_wr;
  logic             xfer_ok;
  logic             reload;
  logic             carry;
  logic             active;
  logic [CNT_W-1:0] cur;
  logic [PG_W-1:0]  page;
  logic [HP_W-1:0]  hpage;
  chan_kind_e       kind;

  assign any_wr  = wr_mode_i | wr_addr_i | wr_count_i | wr_page_i | wr_hpage_i;
  assign xfer_ok = xfer_i & active & ~any_wr;

  dma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .wr_mode_i(wr_mode_i), .wr_count_i(wr_count_i),
    .wr_data_i(wr_data_i), .xfer_ok_i(xfer_ok), .count_o(count_o),
    .active_o(active), .tc_o(tc_o), .reload_o(reload), .kind_o(kind)
  );

  dma_addr_counter #(.CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst(rst), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .xfer_ok_i(xfer_ok), .reload_i(reload), .cur_o(cur), .carry_o(carry)
  );

  dma_page_unit #(.PG_W(PG_W), .HP_W(HP_W)) u_page (
    .clk(clk), .rst(rst), .wr_page_i(wr_page_i), .wr_hpage_i(wr_hpage_i),
    .page_data_i(wr_data_i[PG_W-1:0]), .hpage_data_i(wr_data_i[HP_W-1:0]),
    .carry_i(carry), .reload_i(reload), .kind_i(kind),
    .page_o(page), .hpage_o(hpage), .ext_o(ext_mode_o)
  );

  dma_addr_compose #(.CNT_W(CNT_W), .PG_W(PG_W), .HP_W(HP_W)) u_compose (
    .cur_i(cur), .page_i(page), .hpage_i(hpage), .kind_i(kind), .addr_o(phys_addr_o)
  );

  assign active_o = active;
endmodule

// File: tb/dma_page_addr_gen_tb_top.sv
module dma_page_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_mode_i = 0, wr_addr_i = 0, wr_count_i = 0, wr_page_i = 0, wr_hpage_i = 0;
  logic [15:0] wr_data_i = '0;
  logic        xfer_i = 0;
  logic [31:0] phys_addr_o;
  logic        tc_o, active_o, ext_mode_o;
  logic [15:0] count_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model state
  int m_cur, m_bcur, m_cnt, m_bcnt, m_pg, m_bpg, m_hp, m_bhp;
  bit m_ext, m_act, m_tc, m_auto, m_word;

  always #4 clk = ~clk;

  dma_page_addr_gen dut_i (
    .clk(clk), .rst(rst), .wr_mode_i(wr_mode_i), .wr_addr_i(wr_addr_i),
    .wr_count_i(wr_count_i), .wr_page_i(wr_page_i), .wr_hpage_i(wr_hpage_i),
    .wr_data_i(wr_data_i), .xfer_i(xfer_i), .phys_addr_o(phys_addr_o),
    .tc_o(tc_o), .active_o(active_o), .ext_mode_o(ext_mode_o), .count_o(count_o)
  );

  function automatic longint m_addr();
    if (m_word) return (longint'(m_hp) << 24) + (longint'(m_pg / 2) << 17) + (longint'(m_cur) << 1);
    return (longint'(m_hp) << 24) + (longint'(m_pg) << 16) + longint'(m_cur);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 0; m_bcur = 0; m_cnt = 0; m_bcnt = 0; m_pg = 0; m_bpg = 0;
      m_hp = 0; m_bhp = 0; m_ext = 0; m_act = 0; m_tc = 0; m_auto = 0; m_word = 0;
    end else begin
      m_tc = 0;
      if (wr_mode_i || wr_addr_i || wr_count_i || wr_page_i || wr_hpage_i) begin
        if (wr_mode_i) begin m_auto = wr_data_i[0]; m_word = wr_data_i[1]; end
        if (wr_addr_i) begin m_cur = wr_data_i; m_bcur = wr_data_i; end
        if (wr_count_i) begin m_cnt = wr_data_i; m_bcnt = wr_data_i; m_act = 1; end
        if (wr_page_i) begin m_pg = wr_data_i[7:0]; m_bpg = m_pg; m_ext = 0; end
        if (wr_hpage_i) begin m_hp = wr_data_i[7:0]; m_bhp = m_hp; m_ext = 1; end
      end else if (xfer_i && m_act) begin
        bit wrap;
        wrap = (m_cur == 65535);
        m_cur = (m_cur + 1) % 65536;
        if (wrap && m_ext) begin
          int v;
          if (m_word) begin
            v = (m_hp * 128 + m_pg / 2 + 1) % 32768;
            m_hp = v / 128; m_pg = (v % 128) * 2 + (m_pg % 2);
          end else begin
            v = (m_hp * 256 + m_pg + 1) % 65536;
            m_hp = v / 256; m_pg = v % 256;
          end
        end
        if (m_cnt == 0) begin
          m_tc = 1;
          if (m_auto) begin
            m_cur = m_bcur; m_cnt = m_bcnt; m_pg = m_bpg; m_hp = m_bhp;
          end else begin
            m_cnt = 65535; m_act = 0;
          end
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (longint'(phys_addr_o) != m_addr() || tc_o != m_tc || active_o != m_act ||
          ext_mode_o != m_ext || int'(count_o) != m_cnt) begin
        errors++;
        $display("FAIL %s cycle: addr=%h/%h tc=%0d/%0d act=%0d/%0d ext=%0d/%0d cnt=%h/%h",
                 phase, phys_addr_o, m_addr(), tc_o, m_tc, active_o, m_act,
                 ext_mode_o, m_ext, count_o, m_cnt);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input logic [15:0] d);
    @(negedge clk);
    wr_data_i = d;
    case (kind)
      0: wr_mode_i = 1;
      1: wr_addr_i = 1;
      2: wr_count_i = 1;
      3: wr_page_i = 1;
      default: wr_hpage_i = 1;
    endcase
    @(negedge clk);
    wr_mode_i = 0; wr_addr_i = 0; wr_count_i = 0; wr_page_i = 0; wr_hpage_i = 0;
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    xfer_i = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    xfer_i = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    check("R1 addr", phys_addr_o, 0);
    check("R1 flags", {tc_o, active_o, ext_mode_o}, 0);
    check("R1 count", count_o, 0);

    phase = "R2";
    wr(0, 16'h0000); wr(3, 16'h0012); wr(1, 16'h3456);
    check("R2 byte layout", phys_addr_o, 32'h0012_3456);

    phase = "R7";
    wr(2, 16'd3); xfer(3);
    check("R7 no tc early", tc_o, 0);
    check("R7 count down", count_o, 0);
    xfer(1);
    check("R7 tc on last", tc_o, 1);
    phase = "R8";
    check("R8 inactive", active_o, 0);
    check("R8 count ffff", count_o, 16'hFFFF);
    xfer(2);
    check("R8 addr frozen", phys_addr_o, 32'h0012_345A);

    phase = "R4";
    wr(1, 16'hFFFE); wr(2, 16'd5); xfer(3);
    check("R4 wrap in window", phys_addr_o, 32'h0012_0001);

    phase = "R5";
    wr(4, 16'h00AB);
    check("R5 hpage sets ext", ext_mode_o, 1);
    phase = "R6";
    wr(1, 16'hFFFF); wr(2, 16'd1); xfer(1);
    check("R6 byte carry", phys_addr_o, 32'hAB13_0000);
    phase = "R5";
    wr(3, 16'h00FF);
    check("R5 page clears ext", ext_mode_o, 0);
    wr(4, 16'h0001); wr(1, 16'hFFFF); wr(2, 16'd0);
    phase = "R6";
    xfer(1);
    check("R6 full carry", phys_addr_o, 32'h0200_0000);

    phase = "R3";
    wr(0, 16'h0002); wr(3, 16'h0035); wr(1, 16'h1000);
    check("R3 word layout", phys_addr_o, 32'h0234_2000);
    wr(3, 16'h0034);
    check("R3 page bit0 ignored", phys_addr_o, 32'h0234_2000);
    wr(3, 16'h0035); wr(4, 16'h0007); wr(1, 16'hFFFF); wr(2, 16'd0);
    phase = "R6";
    xfer(1);
    check("R6 word carry", phys_addr_o, 32'h0736_0000);

    phase = "R9";
    wr(0, 16'h0001); wr(3, 16'h0040); wr(1, 16'h0100); wr(2, 16'd1);
    xfer(1);
    check("R9 advancing", phys_addr_o, 32'h0740_0101);
    xfer(1);
    check("R9 tc", tc_o, 1);
    check("R9 addr reload", phys_addr_o, 32'h0740_0100);
    check("R9 count reload", count_o, 1);
    check("R9 still active", active_o, 1);
    wr(4, 16'h0009); wr(1, 16'hFFFF); wr(2, 16'd0); xfer(1);
    check("R9 reload beats carry", phys_addr_o, 32'h0940_FFFF);

    phase = "R10";
    wr(0, 16'h0000); wr(2, 16'd5);
    @(negedge clk);
    wr_addr_i = 1; wr_data_i = 16'h2000; xfer_i = 1;
    @(negedge clk);
    wr_addr_i = 0; xfer_i = 0;
    check("R10 count held", count_o, 5);
    check("R10 addr written", phys_addr_o, 32'h0940_2000);

    phase = "R11";
    wr(0, 16'h0001); wr(1, 16'h0500); wr(2, 16'd0); xfer(1);
    check("R11 base from addr write", phys_addr_o, 32'h0940_0500);

    phase = "R7";
    wr(0, 16'h0000); wr(2, 16'hFFFF); xfer(65535);
    check("R7 65535 done no tc", tc_o, 0);
    check("R7 count at zero", count_o, 0);
    xfer(1);
    check("R7 tc after 65536", tc_o, 1);

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule